// File: doc/BRIEF.md
# Keyed Flash Block-Erase Controller

This block sits between a processor's register bus and an on-chip flash array and carries out erases of whole 1024-byte blocks. Software loads a 22-bit flash address into three pointer byte registers, sets an enable bit and an erase-select bit in a control register, writes the two-byte key 55h then AAh into a key register, and finally sets the start bit. Only that exact order arms the controller. Any other key byte disarms it, and each start attempt uses up the arming.

Once an erase starts, the controller raises a stall output that halts the processor. It latches the block number from address bits 21 to 10 and ignores bits 9 to 0. It raises an erase request to the flash array and holds it until the array acknowledges. An internal timer of a parameter-set length ends the operation. Nothing on the processor side can shorten it. When the timer runs out, the start bit clears, the stall drops, and a done flag pulses for one cycle.

Register selects (`bus_addr`): 0 pointer bits 7:0, 1 pointer bits 15:8, 2 pointer bits 21:16 in data bits 5:0, 3 control, 4 key (write-only, reads 0). Control bits: 1 start, 2 write enable, 4 erase select. All other bits read 0.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset, `stall`, `done` and `fl_erase_req` are 0, and the control and pointer registers read 0.
- R2: A control write with bits 1, 2 and 4 all set, made after a 55h then AA key sequence, starts an erase. From the next cycle `stall` is 1, `fl_erase_req` is 1, and the control register reads 16h. Control writes with bit 1 clear do not use up the arming.
- R3: `fl_block` equals pointer bits 21:10 captured at start, so two pointers that differ only in bits 9:0 select the same block, and it stays constant during the erase.
- R4: A start attempt written with the write-enable bit (bit 2) at 0 is ignored: `stall` stays 0 and the start bit reads 0.
- R5: A start attempt written with the erase-select bit (bit 4) at 0 is ignored. No program or word operation is ever issued.
- R6: Only 55h followed by AAh arms the controller. Any key byte other than the expected next one returns the sequence to idle, so AA-55, 55-12-AA and 55-55-AA leave it unarmed.
- R7: Every start attempt, successful or not, uses up the arming. A failed attempt followed by a valid start write without a new key sequence is ignored.
- R8: `stall` stays high for exactly ERASE_CYCLES clock cycles, whether or not the flash acknowledges.
- R9: In the cycle after `stall` falls, `done` is 1 for exactly one cycle, and the start bit reads 0 again.
- R10: `fl_erase_req` is only high during `stall`. It drops in the cycle after `fl_ack` is 1, and it drops when the timer ends if no acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| stall | output | 1 | Halts the processor while an erase runs |
| done | output | 1 | One-cycle pulse when an erase finishes |
| fl_erase_req | output | 1 | Erase request to the flash array |
| fl_block | output | 12 | Block number sent to the flash array |
| fl_ack | input | 1 | Flash array acknowledge of the request |

## Verification
The assertions assume that the bus performs at most one register write per cycle. They also assume that no write arrives while `stall` is high, because a stalled processor cannot issue one. They further assume that `fl_ack` is only raised while `fl_erase_req` is high. The stimulus issues register writes one at a time through a single task. It waits for `stall` to fall before touching the bus again. Its flash model only acknowledges a pending request, and that acknowledge can be switched off to exercise the timer-only ending.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int PTR_W   = 22;
    localparam int BLK_LSB = 10;
    localparam int BLK_W   = PTR_W - BLK_LSB;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PTR_LO  = 3'd0,
        SEL_PTR_MID = 3'd1,
        SEL_PTR_UP  = 3'd2,
        SEL_CTRL    = 3'd3,
        SEL_KEY     = 3'd4
    } reg_sel_e;

    localparam int CTL_START = 1;
    localparam int CTL_WEN   = 2;
    localparam int CTL_ESEL  = 4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_GOT1  = 2'd1,
        UNL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        logic esel;
        logic wen;
    } ctrl_t;

    function automatic logic [7:0] ctrl_image(ctrl_t c, logic running);
        logic [7:0] v;
        v = '0;
        v[CTL_ESEL]  = c.esel;
        v[CTL_WEN]   = c.wen;
        v[CTL_START] = running;
        return v;
    endfunction

    function automatic logic [BLK_W-1:0] block_of(logic [PTR_W-1:0] p);
        return p[PTR_W-1:BLK_LSB];
    endfunction

endpackage

// File: rtl/flash_erase_regs.sv
module flash_erase_regs
    import flash_erase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic [7:0]           wdata,
    input  logic                 busy,
    output logic [PTR_W-1:0]     ptr,
    output ctrl_t                ctrl,
    output logic [7:0]           rdata
);
    localparam int UP_W = PTR_W - 16;

    logic wr_ok;
    assign wr_ok = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            ctrl <= '0;
        end else if (wr_ok) begin
            case (reg_sel_e'(sel))
                SEL_PTR_LO:  ptr[7:0]       <= wdata;
                SEL_PTR_MID: ptr[15:8]      <= wdata;
                SEL_PTR_UP:  ptr[PTR_W-1:16] <= wdata[UP_W-1:0];
                SEL_CTRL: begin
                    ctrl.wen  <= wdata[CTL_WEN];
                    ctrl.esel <= wdata[CTL_ESEL];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_PTR_LO:  rdata = ptr[7:0];
            SEL_PTR_MID: rdata = ptr[15:8];
            SEL_PTR_UP:  rdata = {{(8-UP_W){1'b0}}, ptr[PTR_W-1:16]};
            SEL_CTRL:    rdata = ctrl_image(ctrl, busy);
            default:     rdata = '0;
        endcase
    end

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(ptr)) else $error("ptr moved while busy"); // R3

endmodule

// File: rtl/flash_erase_unlock.sv
module flash_erase_unlock
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       armed
);
    unlock_e state, state_n;

    always_comb begin
        state_n = state;
        if (consume) begin
            state_n = UNL_IDLE;
        end else if (key_wr) begin
            case (state)
                UNL_IDLE:  state_n = (key_data == KEY_FIRST)  ? UNL_GOT1  : UNL_IDLE;
                UNL_GOT1:  state_n = (key_data == KEY_SECOND) ? UNL_ARMED : UNL_IDLE;
                default:   state_n = UNL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= UNL_IDLE;
        else     state <= state_n;
    end

    assign armed = (state == UNL_ARMED);

    AST_ARM_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(key_wr && key_data == KEY_SECOND)) else $error("armed without AA"); // R6

    AST_FIRST_AFTER_55: assert property (@(posedge clk) disable iff (rst)
        $rose(state == UNL_GOT1) |-> $past(key_wr && key_data == KEY_FIRST)) else $error("step one without 55"); // R6

    AST_ATTEMPT_DISARMS: assert property (@(posedge clk) disable iff (rst)
        consume |=> !armed) else $error("arming survived an attempt"); // R7

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic expiring,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign expiring = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= expiring;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= LOAD;
            end else if (expiring) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done without finished erase"); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than a cycle"); // R9

    AST_BUSY_ENDS_BY_TIMER: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt == '0)) else $error("erase ended early"); // R8

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import flash_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_en,
    input  logic [SEL_W-1:0]     bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 stall,
    output logic                 done,
    output logic                 fl_erase_req,
    output logic [BLK_W-1:0]     fl_block,
    input  logic                 fl_ack
);
    logic [PTR_W-1:0] ptr;
    ctrl_t            ctrl;
    logic             busy;
    logic             expiring;
    logic             armed;
    logic             key_wr;
    logic             start_try;
    logic             start_ok;

    assign key_wr    = bus_wr_en && !busy && (bus_addr == SEL_KEY);
    assign start_try = bus_wr_en && !busy && (bus_addr == SEL_CTRL) && bus_wdata[CTL_START];
    assign start_ok  = start_try && armed && bus_wdata[CTL_WEN] && bus_wdata[CTL_ESEL];

    flash_erase_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr_en),
        .sel   (bus_addr),
        .wdata (bus_wdata),
        .busy  (busy),
        .ptr   (ptr),
        .ctrl  (ctrl),
        .rdata (bus_rdata)
    );

    flash_erase_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .consume  (start_try),
        .armed    (armed)
    );

    flash_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start_ok),
        .busy     (busy),
        .expiring (expiring),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_erase_req <= 1'b0;
            fl_block     <= '0;
        end else if (start_ok) begin
            fl_erase_req <= 1'b1;
            fl_block     <= block_of(ptr);
        end else if (fl_ack || expiring) begin
            fl_erase_req <= 1'b0;
        end
    end

    assign stall = busy;

    AST_START_NEEDS_BITS: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(bus_wr_en && bus_addr == SEL_CTRL && bus_wdata[CTL_WEN]
                                && bus_wdata[CTL_ESEL] && bus_wdata[CTL_START])) else $error("start without enable bits"); // R4

    AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(armed)) else $error("start without key"); // R6

    AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
        stall && $past(stall) |-> $stable(fl_block)) else $error("block changed mid-erase"); // R3

    AST_REQ_INSIDE_STALL: assert property (@(posedge clk) disable iff (rst)
        fl_erase_req |-> stall) else $error("request outside erase"); // R10

    AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        fl_erase_req && fl_ack |=> !fl_erase_req) else $error("request held after ack"); // R10

endmodule

// File: tb/flash_erase_ctl_bench.sv
module flash_erase_ctl_bench;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        stall, done, fl_erase_req, fl_ack;
    logic [11:0] fl_block;

    int checks = 0;
    int fails  = 0;
    bit ack_on = 1'b1;
    bit finished = 1'b0;
    int unsigned exp_q[$];
    int stall_len = 0;
    int req_age = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_erase_ctl #(.ERASE_CYCLES(N)) u_flash_erase_ctl (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall), .done(done),
        .fl_erase_req(fl_erase_req), .fl_block(fl_block), .fl_ack(fl_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ptr(input logic [21:0] p);
        bus_write(3'd0, p[7:0]);
        bus_write(3'd1, p[15:8]);
        bus_write(3'd2, {2'b00, p[21:16]});
    endtask

    task automatic unlock();
        bus_write(3'd4, 8'h55);
        bus_write(3'd4, 8'hAA);
    endtask

    task automatic wait_idle();
        while (stall) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // start attempt that must be ignored: stall stays low, start bit reads 0
    task automatic expect_ignored(input logic [7:0] ctl, input string req);
        logic [7:0] r;
        bus_write(3'd3, ctl);
        repeat (2) @(negedge clk);
        check(stall == 1'b0, req, stall, 0);
        bus_read(3'd3, r);
        check(r[1] == 1'b0, req, r, 0);
    endtask

    // driver: full valid erase, pushes expected block into scoreboard
    task automatic do_erase(input logic [21:0] p, input bit ctl_after_key);
        logic [7:0] r;
        set_ptr(p);
        if (!ctl_after_key) bus_write(3'd3, 8'h14);
        unlock();
        if (ctl_after_key) bus_write(3'd3, 8'h14); // R2: no start bit, keeps arming
        exp_q.push_back(32'(p[21:10]));
        bus_write(3'd3, 8'h16);
        check(stall == 1'b1, "R2 stall", stall, 1);
        check(fl_erase_req == 1'b1, "R2 req", fl_erase_req, 1);
        check(fl_block == p[21:10], "R3 block", fl_block, p[21:10]);
        bus_read(3'd3, r);
        check(r == 8'h16, "R2 ctrl read", r, 8'h16);
        wait_idle();
        bus_read(3'd3, r);
        check(r[1] == 1'b0, "R9 start cleared", r, 0);
    endtask

    // flash model: acknowledge a pending request after two cycles
    always @(negedge clk) begin
        fl_ack <= 1'b0;
        if (rst || !fl_erase_req) req_age <= 0;
        else begin
            req_age <= req_age + 1;
            if (ack_on && req_age == 2) fl_ack <= 1'b1;
        end
    end

    // monitor: scoreboard on done, stall length, request behaviour
    bit prev_done = 1'b0;
    bit prev_ack = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check(done == 1'b0, "R9 done width", done, 0);
            if (prev_ack && stall) check(fl_erase_req == 1'b0, "R10 drop on ack", fl_erase_req, 0);
            if (fl_erase_req) check(stall == 1'b1, "R10 req in stall", stall, 1);
            if (stall) stall_len++;
            if (done) begin
                check(stall == 1'b0, "R9 done after stall", stall, 0);
                check(stall_len == N, "R8 stall length", stall_len, N);
                if (exp_q.size() == 0) check(1'b0, "R2 unexpected done", 1, 0);
                else begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    check(32'(fl_block) == e, "R3 scoreboard block", fl_block, e);
                end
                stall_len = 0;
            end
            prev_done = done;
            prev_ack = fl_ack;
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_up();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(stall == 1'b0, "R1 stall", stall, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(fl_erase_req == 1'b0, "R1 req", fl_erase_req, 0);
        bus_read(3'd3, r); check(r == 8'h00, "R1 ctrl", r, 0);
        bus_read(3'd0, r); check(r == 8'h00, "R1 ptr", r, 0);

        // R2 basic erase
        do_erase(22'h123456, 1'b0);
        // R3 low bits ignored: same block from both ends
        do_erase(22'h0487FF, 1'b1);
        do_erase(22'h048400, 1'b0);

        // R4 write enable clear
        unlock();
        expect_ignored(8'h12, "R4 wen clear");
        bus_read(3'd3, r); check(r == 8'h10, "R4 ctrl kept", r, 8'h10);
        // R5 erase select clear
        unlock();
        expect_ignored(8'h06, "R5 esel clear");
        // R6 wrong key orders
        bus_write(3'd4, 8'hAA); bus_write(3'd4, 8'h55);
        expect_ignored(8'h16, "R6 AA then 55");
        bus_write(3'd4, 8'h55); bus_write(3'd4, 8'h12); bus_write(3'd4, 8'hAA);
        expect_ignored(8'h16, "R6 stray byte");
        bus_write(3'd4, 8'h55); bus_write(3'd4, 8'h55); bus_write(3'd4, 8'hAA);
        expect_ignored(8'h16, "R6 double 55");
        // R7 arming consumed by failed attempt
        unlock();
        expect_ignored(8'h12, "R7 failed attempt");
        expect_ignored(8'h16, "R7 reuse");

        // R8 / R10 no acknowledge: timer alone ends the erase
        ack_on = 1'b0;
        set_ptr(22'h3FFC00);
        unlock();
        exp_q.push_back(32'h0FFF);
        bus_write(3'd3, 8'h16);
        repeat (N - 2) @(negedge clk);
        check(fl_erase_req == 1'b1, "R10 req held", fl_erase_req, 1);
        wait_idle();
        check(fl_erase_req == 1'b0, "R10 req dropped at end", fl_erase_req, 0);
        ack_on = 1'b1;

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 all erases completed", exp_q.size(), 0);
        finish_up();
    end
endmodule